// File: doc/BRIEF.md
# Receive ring buffer writer

This block sits between a receive MAC and on-chip packet memory. It takes received frames as a byte stream and places each one in a circular buffer. In front of every frame it stores a 4-byte descriptor. Byte 0 is a status byte, byte 1 is zero, and bytes 2 and 3 hold the frame length, low byte first. The length counts every byte of the stream, the trailing CRC included. Frame data starts right after its descriptor. The next descriptor starts on the first 4-byte boundary past the frame, and the offset wraps back to the bottom of the buffer when it passes the top.

The host consumes frames and reports its position through a read-pointer register. That register holds the consumed offset minus 16. The block compares its own write offset with the host position to derive the free space and a buffer-empty flag. It drops a frame when there is no room for it and counts the loss in a missed-frame counter. It rejects runt or damaged frames unless the matching accept bit is set. For every frame it raises one of two sticky interrupt flags.

The input is a valid/ready stream. A beat transfers when `s_valid` and `s_ready` are both high. `s_last` marks the final beat, and the two error flags are sampled on that beat. After the final beat, `s_ready` stays low for exactly four cycles while the descriptor is written. It is high at all other times. The source may hold `s_valid` low between beats at will. The memory port is a registered, byte-wide write port. `cfg_size` must only change while the block is held in reset.

Top module: `rxr_ring_writer`

## Requirements
- R1: `s_ready` is high after reset. It falls in the cycle after a beat with `s_last` is accepted, stays low for four cycles, and then rises again.
- R2: Data byte i of a frame that starts at offset W is written to address (W + 4 + i) mod S, where S is the buffer size. Each write appears on the memory port one cycle after the beat.
- R3: When a frame is stored, its descriptor is written to W, W+1, W+2 and W+3 in the four cycles after its last beat. The bytes are status, 0x00, length[7:0] and length[15:8]. If the frame is not stored, none of these four addresses is written.
- R4: The status byte has the following bits. Bit 0 is set when none of the other conditions holds. Bit 1 is the alignment error. Bit 2 is the CRC error. Bit 3 means the length is above 4096. Bit 4 means the length is below 64.
- R5: The write offset is 0 after reset. After a stored frame of length L it advances by (L + 4) rounded up to a multiple of 4. The buffer size is subtracted when the result reaches or passes the size. The offset only moves when a frame is stored.
- R6: The buffer size is 8192 << `cfg_size`. With code 0 the offset wraps at 8192. With code 1 an offset above 8192 is used without wrapping.
- R7: The host read pointer resets to 0xFFF0 and is loaded when `rd_ptr_we` is high. The host offset is (pointer + 16) mod S.
- R8: `buf_empty` is 1 exactly when the write offset equals the host offset.
- R9: The free space F is (host offset − write offset) mod S, taken as S when that value is 0. A frame is stored only if its rounded footprint (L + 4, rounded up to 4) is strictly less than F. A frame that does not fit increments `miss_cnt` and sets `isr_rer`. No byte is ever written at or beyond the host offset.
- R10: A frame with a CRC or alignment error is rejected unless `cfg_acc_err` is set. A frame shorter than 64 bytes is rejected unless `cfg_acc_runt` is set. A rejected frame leaves the offset unchanged, sets `isr_rer` and does not touch `miss_cnt`.
- R11: `isr_rok` is set for a stored frame with status bit 0 set, and `isr_rer` is set for every other frame. Both flags are set in the cycle the descriptor completes and are sticky. A 1 on `isr_clr[0]` clears `isr_rok`, and a 1 on `isr_clr[1]` clears `isr_rer`. A set in the same cycle wins over a clear.
- R12: `miss_cnt` resets to 0. It increases by one per dropped frame and saturates at its maximum. A pulse on `miss_clr` clears it, and the clear wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat ready |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final beat of frame |
| s_crc_err | input | 1 | CRC error, sampled with last beat |
| s_align_err | input | 1 | Alignment error, sampled with last beat |
| cfg_size | input | 2 | Buffer size code |
| cfg_acc_runt | input | 1 | Keep short frames |
| cfg_acc_err | input | 1 | Keep CRC/alignment-error frames |
| rd_ptr_we | input | 1 | Load host read pointer |
| rd_ptr_wdata | input | 16 | Host read pointer (offset − 16) |
| buf_empty | output | 1 | No unread frame stored |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 16 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write byte |
| isr_rok | output | 1 | Good-frame interrupt flag |
| isr_rer | output | 1 | Error/drop interrupt flag |
| isr_clr | input | 2 | Write-one-to-clear for the flags |
| miss_clr | input | 1 | Clear missed-frame counter |
| miss_cnt | output | 16 | Missed-frame counter |

## Verification
On every cycle the assertions check several properties. The write offset stays 4-byte aligned and moves only when a frame is stored. Every memory write falls inside the configured buffer. `s_ready` drops only after a final beat. The overrun mark is sticky within a frame. Each interrupt flag rises only on its own set event. The missed counter only steps by one or returns to zero. The bench scenarios cover the rest: the descriptor and data contents, wrap-around at the selected size, the fit decision against the host pointer, the accept rules for runt and damaged frames, and the proof that a dropped frame writes nothing into unread space.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ST_OK   = 0;
  localparam int ST_FAE  = 1;
  localparam int ST_CRC  = 2;
  localparam int ST_LONG = 3;
  localparam int ST_RUNT = 4;
  localparam int HDR_BYTES = 4;
  localparam int RD_BIAS   = 16;
  localparam int EV_ROK = 0;
  localparam int EV_RER = 1;
  localparam int NUM_EV = 2;
  typedef enum logic {PH_DATA, PH_HDR} phase_t;
endpackage

// File: rtl/rxr_space.sv
module rxr_space import rxr_pkg::*; #(
  parameter int BASE_AW = 13,
  parameter int CODE_W  = 2,
  parameter int OFS_W   = BASE_AW + (1 << CODE_W) - 1,
  parameter int LEN_W   = OFS_W + 2
) (
  input  logic [CODE_W-1:0] cfg_size,
  input  logic [OFS_W-1:0]  wr_off,
  input  logic [OFS_W-1:0]  rd_ptr,
  output logic [OFS_W-1:0]  mask,
  output logic [LEN_W-1:0]  size,
  output logic [LEN_W-1:0]  free,
  output logic              empty
);
  localparam int NCODE = 1 << CODE_W;

  logic [LEN_W-1:0] size_tab [NCODE];
  logic [OFS_W-1:0] host_off;
  logic [OFS_W-1:0] diff;

  for (genvar g = 0; g < NCODE; g++) begin : g_size
    assign size_tab[g] = LEN_W'(1) << (BASE_AW + g);
  end

  assign size     = size_tab[cfg_size];
  assign mask     = OFS_W'(size - LEN_W'(1));
  assign host_off = (rd_ptr + OFS_W'(RD_BIAS)) & mask;
  assign diff     = (host_off - wr_off) & mask;
  assign empty    = (diff == '0);
  assign free     = empty ? size : LEN_W'(diff);
endmodule

// File: rtl/rxr_frame.sv
module rxr_frame import rxr_pkg::*; #(
  parameter int LEN_W   = 18,
  parameter int FLEN_W  = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              last,
  input  logic              crc_in,
  input  logic              fae_in,
  input  logic [LEN_W-1:0]  free,
  input  logic              clear,
  output logic [LEN_W-1:0]  pos,
  output logic              room,
  output logic [FLEN_W-1:0] len,
  output logic              bad,
  output logic              runt,
  output logic              overrun,
  output logic [7:0]        status,
  output logic              ok
);
  logic [FLEN_W-1:0] cnt;
  logic              crc_q, fae_q;
  logic              long_f;

  assign pos  = LEN_W'(HDR_BYTES) + LEN_W'(cnt);
  assign room = pos < free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      len     <= '0;
      crc_q   <= 1'b0;
      fae_q   <= 1'b0;
      overrun <= 1'b0;
    end else if (clear) begin
      cnt     <= '0;
      overrun <= 1'b0;
    end else if (beat) begin
      if (cnt != '1) cnt <= cnt + FLEN_W'(1);
      if (!room) overrun <= 1'b1;
      if (last) begin
        len   <= (cnt == '1) ? cnt : cnt + FLEN_W'(1);
        crc_q <= crc_in;
        fae_q <= fae_in;
      end
    end
  end

  assign runt   = len < FLEN_W'(MIN_LEN);
  assign long_f = len > FLEN_W'(MAX_LEN);
  assign bad    = crc_q | fae_q;
  assign ok     = !bad && !runt && !long_f;

  always_comb begin
    status          = '0;
    status[ST_OK]   = ok;
    status[ST_FAE]  = fae_q;
    status[ST_CRC]  = crc_q;
    status[ST_LONG] = long_f;
    status[ST_RUNT] = runt;
  end

  assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overrun) && !$past(clear)) |-> overrun);
endmodule

// File: rtl/rxr_events.sv
module rxr_events import rxr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] set_ev,
  input  logic [NUM_EV-1:0] clr_ev,
  input  logic              inc,
  input  logic              cnt_clr,
  output logic [NUM_EV-1:0] flags,
  output logic [CNT_W-1:0]  cnt
);
  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[g] <= 1'b0;
      else if (set_ev[g])  flags[g] <= 1'b1;
      else if (clr_ev[g])  flags[g] <= 1'b0;
    end

    assert_flag_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[g]) |-> $past(set_ev[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (cnt_clr)          cnt <= '0;
    else if (inc && cnt != '1) cnt <= cnt + CNT_W'(1);
  end

  assert_miss_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0)));
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer import rxr_pkg::*; #(
  parameter int BASE_AW = 13,
  parameter int CODE_W  = 2,
  parameter int CNT_W   = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic              s_crc_err,
  input  logic              s_align_err,
  input  logic [CODE_W-1:0] cfg_size,
  input  logic              cfg_acc_runt,
  input  logic              cfg_acc_err,
  input  logic              rd_ptr_we,
  input  logic [BASE_AW+(1<<CODE_W)-2:0] rd_ptr_wdata,
  output logic              buf_empty,
  output logic              mem_we,
  output logic [BASE_AW+(1<<CODE_W)-2:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              isr_rok,
  output logic              isr_rer,
  input  logic [NUM_EV-1:0] isr_clr,
  input  logic              miss_clr,
  output logic [CNT_W-1:0]  miss_cnt
);
  localparam int OFS_W  = BASE_AW + (1 << CODE_W) - 1;
  localparam int LEN_W  = OFS_W + 2;
  localparam int FLEN_W = 16;
  localparam logic [OFS_W-1:0] RD_RST = OFS_W'(0) - OFS_W'(RD_BIAS);

  phase_t            phase;
  logic [1:0]        hcnt;
  logic [OFS_W-1:0]  wr_off, rd_ptr;
  logic [OFS_W-1:0]  mask;
  logic [LEN_W-1:0]  size, free;
  logic              empty;
  logic              beat, commit;
  logic [LEN_W-1:0]  pos;
  logic              room;
  logic [FLEN_W-1:0] frm_len;
  logic              frm_bad, frm_runt, frm_ovr, frm_ok;
  logic [7:0]        frm_status;
  logic [LEN_W-1:0]  foot, sum, nxt;
  logic              fits, accept, store;
  logic [7:0]        hdr_byte;
  logic [OFS_W-1:0]  data_addr;
  logic [NUM_EV-1:0] set_ev, flags;
  logic              inc_miss;

  assign s_ready   = (phase == PH_DATA);
  assign beat      = s_valid && s_ready;
  assign commit    = (phase == PH_HDR) && (hcnt == 2'd3);
  assign buf_empty = empty;

  rxr_space #(.BASE_AW(BASE_AW), .CODE_W(CODE_W), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_space (
    .cfg_size(cfg_size), .wr_off(wr_off), .rd_ptr(rd_ptr),
    .mask(mask), .size(size), .free(free), .empty(empty)
  );

  rxr_frame #(.LEN_W(LEN_W), .FLEN_W(FLEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(s_last),
    .crc_in(s_crc_err), .fae_in(s_align_err), .free(free), .clear(commit),
    .pos(pos), .room(room), .len(frm_len), .bad(frm_bad), .runt(frm_runt),
    .overrun(frm_ovr), .status(frm_status), .ok(frm_ok)
  );

  // footprint of descriptor plus frame, rounded up to a dword
  assign foot   = (LEN_W'(frm_len) + LEN_W'(HDR_BYTES + 3)) & ~LEN_W'(3);
  assign fits   = !frm_ovr && (foot < free);
  assign accept = (!frm_bad || cfg_acc_err) && (!frm_runt || cfg_acc_runt);
  assign store  = accept && fits;
  assign sum    = LEN_W'(wr_off) + foot;
  assign nxt    = (sum >= size) ? (sum - size) : sum;

  assign data_addr = OFS_W'(LEN_W'(wr_off) + pos) & mask;

  always_comb begin
    case (hcnt)
      2'd0:    hdr_byte = frm_status;
      2'd1:    hdr_byte = 8'h00;
      2'd2:    hdr_byte = frm_len[7:0];
      default: hdr_byte = frm_len[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_DATA;
      hcnt   <= '0;
      wr_off <= '0;
      rd_ptr <= RD_RST;
    end else begin
      if (rd_ptr_we) rd_ptr <= rd_ptr_wdata;
      case (phase)
        PH_DATA: begin
          if (beat && s_last) begin
            phase <= PH_HDR;
            hcnt  <= '0;
          end
        end
        default: begin
          hcnt <= hcnt + 2'd1;
          if (commit) begin
            phase <= PH_DATA;
            if (store) wr_off <= OFS_W'(nxt);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (phase == PH_HDR) begin
      mem_we    <= store;
      mem_addr  <= wr_off + OFS_W'(hcnt);
      mem_wdata <= hdr_byte;
    end else begin
      mem_we <= beat && room;
      if (beat) begin
        mem_addr  <= data_addr;
        mem_wdata <= s_data;
      end
    end
  end

  assign set_ev[EV_ROK] = commit && store && frm_ok;
  assign set_ev[EV_RER] = commit && !(store && frm_ok);
  assign inc_miss       = commit && accept && !fits;

  rxr_events #(.CNT_W(CNT_W)) u_ev (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(isr_clr),
    .inc(inc_miss), .cnt_clr(miss_clr), .flags(flags), .cnt(miss_cnt)
  );
  assign isr_rok = flags[EV_ROK];
  assign isr_rer = flags[EV_RER];

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_ready) |-> $past(s_valid && s_last));
  assert_wr_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off[1:0] == 2'b00);
  assert_wr_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off != $past(wr_off)) |-> $past(phase == PH_HDR));
  assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr <= mask));
endmodule

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic s_valid = 0, s_last = 0, s_crc_err = 0, s_align_err = 0;
  logic [7:0] s_data = 0;
  logic s_ready;
  logic [1:0] cfg_size = 0;
  logic cfg_acc_runt = 0, cfg_acc_err = 0;
  logic rd_ptr_we = 0;
  logic [15:0] rd_ptr_wdata = 0;
  logic buf_empty, mem_we, isr_rok, isr_rer;
  logic [15:0] mem_addr, miss_cnt;
  logic [7:0] mem_wdata;
  logic [1:0] isr_clr = 0;
  logic miss_clr = 0;

  rxr_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_crc_err(s_crc_err), .s_align_err(s_align_err),
    .cfg_size(cfg_size), .cfg_acc_runt(cfg_acc_runt), .cfg_acc_err(cfg_acc_err),
    .rd_ptr_we(rd_ptr_we), .rd_ptr_wdata(rd_ptr_wdata), .buf_empty(buf_empty),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .isr_rok(isr_rok), .isr_rer(isr_rer), .isr_clr(isr_clr),
    .miss_clr(miss_clr), .miss_cnt(miss_cnt)
  );

  int tests = 0, fails = 0;
  logic [7:0] mem [int];
  bit chk_en = 0;
  int size_m = 8192, wr_m = 0, rd_m = 16'hFFF0, miss_m = 0;
  bit rok_m = 0, rer_m = 0, rdy_m = 1;

  function automatic int host_off();
    return (rd_m + 16) % size_m;
  endfunction
  function automatic int free_m();
    int d;
    d = (host_off() - wr_m + size_m) % size_m;
    return (d == 0) ? size_m : d;
  endfunction

  task automatic check(bit c, string req, int act, int exp);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference model, and write capture
  always @(negedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (chk_en) begin
      check(s_ready == rdy_m, "R1 ready", s_ready, rdy_m);
      check(buf_empty == (wr_m == host_off()), "R8 empty", buf_empty, wr_m == host_off());
      check(isr_rok == rok_m, "R11 rok", isr_rok, rok_m);
      check(isr_rer == rer_m, "R11 rer", isr_rer, rer_m);
      check(int'(miss_cnt) == miss_m, "R12 miss", miss_cnt, miss_m);
    end
  end

  task automatic send(int n, bit crc, bit fae, int seed);
    int f, foot, wr0, ho, ok, runt, lng, st, acc, fits, store, bad;
    f = free_m(); wr0 = wr_m; ho = host_off();
    foot = ((n + 7) / 4) * 4;
    runt = (n < 64); lng = (n > 4096);
    ok = !crc && !fae && !runt && !lng;
    st = ok | (fae << 1) | (crc << 2) | (lng << 3) | (runt << 4);
    acc = (!(crc || fae) || cfg_acc_err) && (!runt || cfg_acc_runt);
    fits = foot < f;
    store = acc && fits;
    mem.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1; s_data = 8'((seed + i) & 8'hFF); s_last = (i == n - 1);
      s_crc_err = crc; s_align_err = fae;
      @(posedge clk);
    end
    rdy_m = 0;
    @(negedge clk);
    s_valid = 0; s_last = 0; s_crc_err = 0; s_align_err = 0;
    repeat (4) @(posedge clk);
    rdy_m = 1;
    if (store) wr_m = (wr_m + foot) % size_m;
    if (store && ok) rok_m = 1; else rer_m = 1;
    if (acc && !fits && miss_m < 65535) miss_m++;
    @(negedge clk); #1;
    if (store) begin
      bad = 0;
      check(mem.exists(wr0) && mem[wr0] == 8'(st), "R3/R4 status byte", mem.exists(wr0) ? mem[wr0] : -1, st);
      check(mem.exists(wr0+1) && mem[wr0+1] == 8'h00, "R3 zero byte", mem.exists(wr0+1) ? mem[wr0+1] : -1, 0);
      check(mem.exists(wr0+2) && mem[wr0+2] == 8'(n & 255), "R3 len lo", mem.exists(wr0+2) ? mem[wr0+2] : -1, n & 255);
      check(mem.exists(wr0+3) && mem[wr0+3] == 8'(n >> 8), "R3 len hi", mem.exists(wr0+3) ? mem[wr0+3] : -1, n >> 8);
      for (int i = 0; i < n; i++) begin
        int a;
        a = (wr0 + 4 + i) % size_m;
        if (!mem.exists(a) || mem[a] != 8'((seed + i) & 8'hFF)) bad++;
      end
      check(bad == 0, "R2 R6 data placement", bad, 0);
    end else begin
      check(!mem.exists(wr0), "R3 no descriptor on drop", mem.exists(wr0), 0);
      if (!fits) check(!mem.exists(ho), "R9 unread byte untouched", mem.exists(ho), 0);
    end
  endtask

  task automatic set_rd(int off);
    @(negedge clk);
    rd_ptr_we = 1; rd_ptr_wdata = 16'((off - 16) & 16'hFFFF);
    @(posedge clk);
    rd_m = (off - 16) & 16'hFFFF;
    @(negedge clk);
    rd_ptr_we = 0;
  endtask

  task automatic clr_isr(logic [1:0] v);
    @(negedge clk);
    isr_clr = v;
    @(posedge clk);
    if (v[0]) rok_m = 0;
    if (v[1]) rer_m = 0;
    @(negedge clk);
    isr_clr = 0;
  endtask

  task automatic clr_miss();
    @(negedge clk);
    miss_clr = 1;
    @(posedge clk);
    miss_m = 0;
    @(negedge clk);
    miss_clr = 0;
  endtask

  task automatic do_reset(logic [1:0] code);
    chk_en = 0;
    @(negedge clk);
    rst_n = 0; cfg_size = code;
    repeat (3) @(posedge clk);
    size_m = 8192 << code; wr_m = 0; rd_m = 16'hFFF0; miss_m = 0;
    rok_m = 0; rer_m = 0; rdy_m = 1;
    @(negedge clk);
    rst_n = 1;
    #1;
    check(s_ready == 1, "R1 reset ready", s_ready, 1);
    check(buf_empty == 1, "R7 R8 reset empty", buf_empty, 1);
    check(isr_rok == 0 && isr_rer == 0, "R11 reset flags", {isr_rer, isr_rok}, 0);
    check(miss_cnt == 0, "R12 reset count", miss_cnt, 0);
    chk_en = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(2'd0);
    send(100, 0, 0, 1);
    check(wr_m == 104, "R5 offset after 100", wr_m, 104);
    clr_isr(2'b11);
    send(70, 0, 0, 7);                 // R5 rounding: 74 -> 76
    send(40, 0, 0, 9);                 // R10 runt rejected
    cfg_acc_runt = 1;
    send(40, 0, 0, 11);                // R4 runt kept, status 0x10
    clr_isr(2'b11);
    send(80, 1, 0, 13);                // R10 crc rejected
    cfg_acc_err = 1;
    send(80, 1, 0, 15);                // R4 crc kept 0x04
    send(80, 0, 1, 17);                // R4 align kept 0x02
    set_rd(wr_m);                      // R7 host catches up
    clr_isr(2'b11);
    for (int k = 0; k < 6; k++) send(1500, 0, 0, 20 + k);   // R9 sixth dropped
    check(miss_m == 1, "R9 one drop counted", miss_cnt, 1);
    clr_miss();                        // R12
    set_rd(wr_m);
    for (int k = 0; k < 4; k++) send(1500, 0, 0, 40 + k);   // R6 wrap at 8192
    clr_isr(2'b01);
    do_reset(2'd1);
    send(4100, 0, 0, 3);               // R4 long 0x08
    send(4100, 0, 0, 5);
    send(100, 0, 0, 6);                // R6 header at 8208
    check(wr_m == 8312, "R6 no wrap at 16K", wr_m, 8312);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule